// File: doc/BRIEF.md
# Multi-source priority interrupt arbiter

The arbiter gathers interrupt requests from several kinds of source and compares them against the processor's current priority level, a number from 0 to 31. Every cycle it reports the highest level that may interrupt the processor now, with 0 meaning that none may. The processor acknowledges by raising `ack_i` while that level is shown. In the same cycle the arbiter puts the matching vector on `vec_o`, and at the next clock edge it withdraws the request that was served.

There are three kinds of source. The halt pin, the memory-error line and the corrected-read-error line are level inputs that the arbiter does not latch. The interval clock, four hardware request levels with sixteen slots each, console receive and console transmit, and software request bits 1 to 15 are latched from one-cycle set pulses and cleared by acknowledge. The levels and vectors of the fixed sources are parameters. The hardware vector is derived from a base address, the level and the slot.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, no latched request is held, and with halt, memory error and corrected-read error low the output level is 0.
- R2: A high halt input gives level 31 whatever the current priority level is. Acknowledging it returns vector 0 and clears nothing.
- R3: Memory error (level 0x1D), corrected-read error (0x1A) and the clock request (0x18) are taken in that order, each only when the current priority level is strictly below its own level. Acknowledging memory error returns vector 0x60 and acknowledging corrected-read error returns 0x54. Neither acknowledge clears anything, because both are level inputs.
- R4: Hardware levels 0x14 to 0x17 (slot bits hw_set_i[16*k+s] for level 0x14+k, slot s) are scanned from the highest down. The first level with any slot pending wins. When the scan meets a level at or below the current priority level, the output is 0, even if a console or software request is pending.
- R5: Acknowledging hardware level L returns vector 0x100 + (L-0x14)*0x40 + s*4, where s is the lowest pending slot, and clears only that slot.
- R6: The console request has level 0x14. It is taken when receive or transmit is pending and the current priority level is below 0x14. An acknowledge serves receive first (vector 0xF8), then transmit (vector 0xFC), clearing the one it serves.
- R7: Acknowledging the clock level returns vector 0xC0 and clears the clock request.
- R8: Software requests count only when the current priority level is below 15. Only bits above the current level are eligible, and the highest eligible bit n wins with level n. Acknowledging it returns vector 0x80 + 4*n and clears bit n. Set pulses on bit 0 are ignored.
- R9: A set pulse that arrives in the same cycle as the acknowledge that clears that request leaves the request set.
- R10: An acknowledge while the output level is 0 returns vector 0 and changes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ipl_i | input | 5 | Current processor priority level |
| halt_i | input | 1 | Halt pin, level |
| memerr_i | input | 1 | Memory error, level |
| crderr_i | input | 1 | Corrected-read error, level |
| clk_set_i | input | 1 | Interval clock request pulse |
| hw_set_i | input | 64 | Hardware slot set pulses, 16 per level |
| rx_set_i | input | 1 | Console receive request pulse |
| tx_set_i | input | 1 | Console transmit request pulse |
| sw_set_i | input | 16 | Software request set pulses |
| ack_i | input | 1 | Acknowledge of the shown level |
| irq_lvl_o | output | 5 | Highest eligible level, 0 for none |
| vec_o | output | 16 | Vector, valid while ack_i is high |

## Verification
The level output is combinational from the latched requests, so a wrongly set or lost request bit shows on `irq_lvl_o` in the very cycle that its level becomes the highest eligible. A slot or console flag cleared in the wrong place shows up at a later acknowledge, as a wrong or repeated vector. The stimulus drains queued requests through repeated acknowledges, so an error of this kind reaches `vec_o` within a few cycles.

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int LW      = 5,
  parameter int VW      = 16,
  parameter int SLOTS   = 16,
  parameter int HW_LVLS = 4,
  parameter int SW_TOP  = 15,
  parameter logic [LW-1:0] LVL_HALT = 5'h1F,
  parameter logic [LW-1:0] LVL_MEM  = 5'h1D,
  parameter logic [LW-1:0] LVL_CRD  = 5'h1A,
  parameter logic [LW-1:0] LVL_CLK  = 5'h18,
  parameter logic [LW-1:0] LVL_HW0  = 5'h14,
  parameter logic [LW-1:0] LVL_CON  = 5'h14,
  parameter logic [VW-1:0] VEC_MEM  = 16'h0060,
  parameter logic [VW-1:0] VEC_CRD  = 16'h0054,
  parameter logic [VW-1:0] VEC_CLK  = 16'h00C0,
  parameter logic [VW-1:0] VEC_HW   = 16'h0100,
  parameter logic [VW-1:0] VEC_RX   = 16'h00F8,
  parameter logic [VW-1:0] VEC_TX   = 16'h00FC,
  parameter logic [VW-1:0] VEC_SW   = 16'h0080
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LW-1:0]            ipl_i,
  input  logic                     halt_i,
  input  logic                     memerr_i,
  input  logic                     crderr_i,
  input  logic                     clk_set_i,
  input  logic [HW_LVLS*SLOTS-1:0] hw_set_i,
  input  logic                     rx_set_i,
  input  logic                     tx_set_i,
  input  logic [SW_TOP:0]          sw_set_i,
  input  logic                     ack_i,
  output logic [LW-1:0]            irq_lvl_o,
  output logic [VW-1:0]            vec_o
);
  localparam int HIW = (HW_LVLS > 1) ? $clog2(HW_LVLS) : 1;
  localparam int SLW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SIW = $clog2(SW_TOP + 1);

  typedef enum logic [2:0] {
    SRC_NONE, SRC_HALT, SRC_MEM, SRC_CRD, SRC_CLK, SRC_HW, SRC_CON, SRC_SW
  } src_e;

  logic                           clk_req_q;
  logic [HW_LVLS-1:0][SLOTS-1:0]  hw_q;
  logic                           rx_q, tx_q;
  logic [SW_TOP:0]                sw_q;

  src_e           src;
  logic [LW-1:0]  lvl;
  logic [HIW-1:0] hw_sel;
  logic [SLW-1:0] slot;
  logic [SIW-1:0] sw_sel;
  logic           stop;
  logic [VW-1:0]  vec;

  always_comb begin
    src = SRC_NONE; lvl = '0; hw_sel = '0; sw_sel = '0; stop = 1'b0;
    if (halt_i) begin
      src = SRC_HALT; lvl = LVL_HALT;
    end else if (ipl_i < LVL_MEM && memerr_i) begin
      src = SRC_MEM; lvl = LVL_MEM;
    end else if (ipl_i < LVL_CRD && crderr_i) begin
      src = SRC_CRD; lvl = LVL_CRD;
    end else if (ipl_i < LVL_CLK && clk_req_q) begin
      src = SRC_CLK; lvl = LVL_CLK;
    end else begin
      for (int i = HW_LVLS - 1; i >= 0; i--) begin
        if (src == SRC_NONE && !stop) begin
          if (LVL_HW0 + LW'(i) <= ipl_i) stop = 1'b1;
          else if (|hw_q[i]) begin
            src = SRC_HW; lvl = LVL_HW0 + LW'(i); hw_sel = HIW'(i);
          end
        end
      end
      if (src == SRC_NONE && !stop) begin
        if (ipl_i < LVL_CON && (rx_q || tx_q)) begin
          src = SRC_CON; lvl = LVL_CON;
        end else if (ipl_i < LW'(SW_TOP)) begin
          for (int j = 1; j <= SW_TOP; j++) begin
            if (LW'(j) > ipl_i && sw_q[j]) begin
              src = SRC_SW; lvl = LW'(j); sw_sel = SIW'(j);
            end
          end
        end
      end
    end
  end

  always_comb begin
    slot = '0;
    for (int k = SLOTS - 1; k >= 0; k--)
      if (hw_q[hw_sel][k]) slot = SLW'(k);
  end

  always_comb begin
    case (src)
      SRC_MEM: vec = VEC_MEM;
      SRC_CRD: vec = VEC_CRD;
      SRC_CLK: vec = VEC_CLK;
      SRC_HW:  vec = VEC_HW + (VW'(hw_sel) << 6) + (VW'(slot) << 2);
      SRC_CON: vec = rx_q ? VEC_RX : VEC_TX;
      SRC_SW:  vec = VEC_SW + (VW'(sw_sel) << 2);
      default: vec = '0;
    endcase
  end

  assign irq_lvl_o = lvl;
  assign vec_o     = ack_i ? vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_req_q <= 1'b0;
      hw_q      <= '0;
      rx_q      <= 1'b0;
      tx_q      <= 1'b0;
      sw_q      <= '0;
    end else begin
      clk_req_q <= (clk_req_q && !(ack_i && src == SRC_CLK)) || clk_set_i;
      for (int i = 0; i < HW_LVLS; i++)
        for (int k = 0; k < SLOTS; k++)
          hw_q[i][k] <= (hw_q[i][k] && !(ack_i && src == SRC_HW &&
                         hw_sel == HIW'(i) && slot == SLW'(k)))
                        || hw_set_i[i*SLOTS+k];
      rx_q <= (rx_q && !(ack_i && src == SRC_CON)) || rx_set_i;
      tx_q <= (tx_q && !(ack_i && src == SRC_CON && !rx_q)) || tx_set_i;
      sw_q[0] <= 1'b0;
      for (int j = 1; j <= SW_TOP; j++)
        sw_q[j] <= (sw_q[j] && !(ack_i && src == SRC_SW && sw_sel == SIW'(j)))
                   || sw_set_i[j];
    end
  end
endmodule

module irq_prio_arb_chk #(
  parameter int LW = 5,
  parameter int VW = 16,
  parameter logic [LW-1:0] LVL_HALT = 5'h1F,
  parameter logic [LW-1:0] LVL_MEM  = 5'h1D,
  parameter logic [LW-1:0] LVL_CLK  = 5'h18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] ipl_i,
  input logic          halt_i,
  input logic          memerr_i,
  input logic          clk_set_i,
  input logic          ack_i,
  input logic [LW-1:0] irq_lvl_o,
  input logic [VW-1:0] vec_o,
  input logic          clk_req_q
);
  a_r2_halt_top: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |-> irq_lvl_o == LVL_HALT);

  a_r3_memerr_first: assert property (@(posedge clk) disable iff (!rst_n)
    (memerr_i && !halt_i && ipl_i < LVL_MEM) |-> irq_lvl_o == LVL_MEM);

  a_r4_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_o != '0 && !halt_i) |-> irq_lvl_o > ipl_i);

  a_r7_clk_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_lvl_o == LVL_CLK && !clk_set_i) |=> !clk_req_q);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clk_set_i |=> clk_req_q);

  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_lvl_o == '0) |-> vec_o == '0);
endmodule

bind irq_prio_arb irq_prio_arb_chk #(
  .LW(LW), .VW(VW), .LVL_HALT(LVL_HALT), .LVL_MEM(LVL_MEM), .LVL_CLK(LVL_CLK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ipl_i(ipl_i), .halt_i(halt_i),
  .memerr_i(memerr_i), .clk_set_i(clk_set_i), .ack_i(ack_i),
  .irq_lvl_o(irq_lvl_o), .vec_o(vec_o), .clk_req_q(clk_req_q)
);

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ipl_i = '0;
  logic        halt_i = 1'b0, memerr_i = 1'b0, crderr_i = 1'b0;
  logic        clk_set_i = 1'b0, rx_set_i = 1'b0, tx_set_i = 1'b0, ack_i = 1'b0;
  logic [63:0] hw_set_i = '0;
  logic [15:0] sw_set_i = '0;
  logic [4:0]  irq_lvl_o;
  logic [15:0] vec_o;

  int checks = 0;
  int fails  = 0;

  logic        m_clk, m_rx, m_tx;
  logic [63:0] m_hw;
  logic [15:0] m_sw;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arb dut_i (
    .clk(clk), .rst_n(rst_n), .ipl_i(ipl_i), .halt_i(halt_i),
    .memerr_i(memerr_i), .crderr_i(crderr_i), .clk_set_i(clk_set_i),
    .hw_set_i(hw_set_i), .rx_set_i(rx_set_i), .tx_set_i(tx_set_i),
    .sw_set_i(sw_set_i), .ack_i(ack_i), .irq_lvl_o(irq_lvl_o), .vec_o(vec_o)
  );

  // src: 0 none, 1 halt, 2 mem, 3 crd, 4 clk, 5 hw, 6 con, 7 sw
  task automatic predict(output int src, output logic [4:0] lvl,
                         output logic [15:0] vec, output int hl,
                         output int sl, output int sb);
    int ip;
    ip = int'(ipl_i);
    src = 0; lvl = 0; vec = 0; hl = 0; sl = 0; sb = 0;
    if (halt_i) begin src = 1; lvl = 31; end
    else if (memerr_i && ip < 'h1D) begin src = 2; lvl = 5'h1D; vec = 16'h60; end
    else if (crderr_i && ip < 'h1A) begin src = 3; lvl = 5'h1A; vec = 16'h54; end
    else if (m_clk && ip < 'h18) begin src = 4; lvl = 5'h18; vec = 16'hC0; end
    else begin
      bool_scan: for (int L = 'h17; L >= 'h14; L--) begin
        if (L <= ip) begin src = -1; break; end
        if (m_hw[(L-'h14)*16 +: 16] != 0) begin
          src = 5; lvl = 5'(L); hl = L - 'h14;
          for (int s = 15; s >= 0; s--) if (m_hw[hl*16+s]) sl = s;
          vec = 16'(16'h100 + hl*64 + sl*4);
          break;
        end
      end
      if (src == -1) src = 0;
      else if (src == 0) begin
        if ((m_rx || m_tx) && ip < 'h14) begin
          src = 6; lvl = 5'h14; vec = m_rx ? 16'hF8 : 16'hFC;
        end else if (ip < 15) begin
          for (int n = 15; n > ip; n--)
            if (m_sw[n]) begin src = 7; lvl = 5'(n); sb = n; vec = 16'(16'h80 + n*4); break; end
        end
      end
    end
    if (!ack_i) vec = 0;
  endtask

  task automatic cyc();
    int src, hl, sl, sb;
    logic [4:0] el;
    logic [15:0] ev;
    string tag;
    bit coll;
    #1;
    predict(src, el, ev, hl, sl, sb);
    coll = ack_i && ((src == 4 && clk_set_i) || (src == 5 && hw_set_i[hl*16+sl]) ||
                     (src == 7 && sw_set_i[sb]));
    case (src)
      0: tag = ack_i ? "R10" : "R4";
      1: tag = "R2";
      2, 3: tag = "R3";
      4: tag = ack_i ? "R7" : "R3";
      5: tag = ack_i ? "R5" : "R4";
      6: tag = "R6";
      default: tag = "R8";
    endcase
    if (coll) tag = "R9";
    checks++;
    if (irq_lvl_o !== el || vec_o !== ev) begin
      fails++;
      $display("FAIL %s: lvl=%0h vec=%0h expected lvl=%0h vec=%0h",
               tag, irq_lvl_o, vec_o, el, ev);
    end
    if (ack_i) case (src)
      4: m_clk = 1'b0;
      5: m_hw[hl*16+sl] = 1'b0;
      6: if (m_rx) m_rx = 1'b0; else m_tx = 1'b0;
      7: m_sw[sb] = 1'b0;
      default: ;
    endcase
    m_clk = m_clk | clk_set_i;
    m_hw  = m_hw | hw_set_i;
    m_rx  = m_rx | rx_set_i;
    m_tx  = m_tx | tx_set_i;
    m_sw  = m_sw | (sw_set_i & 16'hFFFE);
    @(posedge clk);
    @(negedge clk);
    clk_set_i = 0; hw_set_i = '0; rx_set_i = 0; tx_set_i = 0; sw_set_i = '0; ack_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    m_clk = 0; m_rx = 0; m_tx = 0; m_hw = '0; m_sw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1; checks++;
    if (irq_lvl_o !== 5'h0) begin
      fails++; $display("FAIL R1: lvl=%0h expected 0", irq_lvl_o);
    end
    // R2 halt at top priority level
    ipl_i = 31; halt_i = 1; cyc();
    ipl_i = 31; halt_i = 1; ack_i = 1; cyc();
    halt_i = 0; ipl_i = 0;
    // R7 clock, then R9 set during ack
    clk_set_i = 1; cyc();
    ack_i = 1; clk_set_i = 1; cyc();
    ack_i = 1; cyc();
    cyc();
    // R5 two slots on level 0x16
    hw_set_i[2*16+3] = 1; hw_set_i[2*16+9] = 1; cyc();
    ack_i = 1; cyc();
    ack_i = 1; cyc();
    // R4 scan stop: hw 0x14 pending, sw and console pending, ipl 0x14
    hw_set_i[0] = 1; sw_set_i[5] = 1; rx_set_i = 1; tx_set_i = 1; ipl_i = 5'h14; cyc();
    ipl_i = 5'h13; cyc();
    ack_i = 1; cyc();
    // R6 console order
    ipl_i = 0; ack_i = 1; cyc();
    ack_i = 1; cyc();
    // R8 software masking
    sw_set_i[9] = 1; ipl_i = 5; cyc();
    ipl_i = 9; cyc();
    ipl_i = 15; cyc();
    ipl_i = 5; ack_i = 1; cyc();
    ipl_i = 4; ack_i = 1; cyc();
    // R3 memory error, corrected-read error
    memerr_i = 1; crderr_i = 1; ipl_i = 5'h1C; ack_i = 1; cyc();
    ipl_i = 5'h1D; cyc();
    ipl_i = 5'h19; ack_i = 1; cyc();
    memerr_i = 0; crderr_i = 0;
    // R10 idle acknowledge
    ipl_i = 31; ack_i = 1; cyc();
    // random
    for (int t = 0; t < 4000; t++) begin
      ipl_i     = ($urandom % 2) ? 5'($urandom % 8) : 5'($urandom % 32);
      halt_i    = ($urandom % 64) == 0;
      memerr_i  = ($urandom % 16) == 0;
      crderr_i  = ($urandom % 16) == 0;
      clk_set_i = ($urandom % 8) == 0;
      hw_set_i  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                  & {$urandom, $urandom};
      rx_set_i  = ($urandom % 8) == 0;
      tx_set_i  = ($urandom % 8) == 0;
      sw_set_i  = 16'($urandom & $urandom & $urandom);
      ack_i     = ($urandom % 3) != 0;
      cyc();
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule